// File: doc/BRIEF.md
# SPI Master Byte Shift Engine

This block moves 8-bit words between two on-chip byte queues and an SPI bus that it masters. Software-side logic pushes bytes into a transmit queue; the engine pops each one, shifts it out on MOSI with the most significant bit first, and at the same time assembles the byte arriving on MISO. Each assembled byte goes into a receive queue, which the host drains through a pop port. Every byte sent yields exactly one received byte. SCLK comes from the block clock through a power-of-two divider.

The caller supplies the clock polarity, the clock phase and the divider exponent as level inputs. Polarity and phase are captured only when the engine is idle and the enable input has just risen after being low. Any change made while the block stays enabled therefore cannot produce a stray SCLK edge. The engine drives four slave-select lines, which are all high when no slave is selected. In direct mode the lines are one-hot active low. In decode mode they carry the slave index as a binary code for an external decoder.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, sclk is 0, ss_n is 4'b1111, busy is 0, rx_empty is 1 and tx_full is 0.
- R2: Bytes leave on mosi most significant bit first. Each sent byte produces one received byte made of the miso bits sampled on the sampling edges, with the first-sampled bit as bit 7.
- R3: Inside a byte, consecutive SCLK transitions lie 2^d block clock cycles apart, where d is the 3-bit div input. A div value of 0 acts as 1. The value of div is taken when a byte starts.
- R4: While the engine is idle, sclk sits at the captured polarity. The first transition of each byte moves sclk away from that level.
- R5: With phase 0, miso is sampled on transitions 1, 3, …, 15 and mosi changes on the even transitions. With phase 1, miso is sampled on transitions 2, 4, …, 16 and mosi changes on the odd transitions after the first.
- R6: Polarity and phase are captured only in an idle cycle in which en is 1 and en was seen low in an earlier idle cycle. A change made while the block stays enabled has no effect on sclk or on sampling.
- R7: When en falls during a byte, that byte completes, including its receive push, and no further byte starts.
- R8: When sel_on is 0, ss_n is 4'b1111 one cycle later. When sel_on is 1 and sel_decode is 0, the line numbered sel_idx is low and the others are high.
- R9: When sel_on is 1 and sel_decode is 1, ss_n carries sel_idx zero-extended as a binary number one cycle later. For example, index 2 gives 4'b0010.
- R10: Both queues hold DEPTH (128) bytes. A push into a full transmit queue is ignored and tx_full reads 1. A byte received while the receive queue is full is dropped, and the older contents are kept.
- R11: busy is 1 while the transmit queue holds a byte or a byte is shifting. This holds even when en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; a rise while idle captures the mode |
| cpol | input | 1 | Requested SCLK idle level |
| cpha | input | 1 | Requested phase (0: sample on leading edge) |
| div | input | 3 | Divider exponent; SCLK = clk / 2^(div+1) |
| sel_on | input | 1 | Select a slave |
| sel_decode | input | 1 | 1: binary code on ss_n, 0: one-hot active low |
| sel_idx | input | 2 | Index of the slave to select |
| tx_push | input | 1 | Write tx_data into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue (show-ahead) |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | Transmit queue not empty or byte shifting |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Slave-select lines |

## Verification
The bound checker watches the slave-select encoding, the SCLK level while idle, the freezing of polarity and phase during a byte, and the busy flag on every cycle. Other properties appear only in the bench's scenarios, where miso is looped back inverted. The bench uses these to show the bit order, the sampling edge for each mode, the SCLK spacing for each divider value, and the finish-the-byte behaviour when enable drops. The same holds for a mode change that is ignored while enabled, and for queue-full handling at both ends.

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int DEPTH = 128,
  parameter int NSS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(NSS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [2:0]    div,
  input  logic          sel_on,
  input  logic          sel_decode,
  input  logic [SW-1:0] sel_idx,
  input  logic          tx_push,
  input  logic [7:0]    tx_data,
  output logic          tx_full,
  input  logic          rx_pop,
  output logic [7:0]    rx_data,
  output logic          rx_empty,
  output logic          busy,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic [NSS-1:0] ss_n
);
  timeunit 1ns; timeprecision 100ps;

  logic [7:0] tx_mem [DEPTH];
  logic [7:0] rx_mem [DEPTH];
  logic [AW:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic tx_empty, rx_full;

  logic       armed, cpol_l, cpha_l, shifting, sclk_r;
  logic [6:0] tick, half_m1;
  logic [3:0] ecnt;
  logic [7:0] sh, rx_sh;
  logic [NSS-1:0] ss_q;

  assign tx_empty = (tx_wp == tx_rp);
  assign tx_full  = (tx_wp[AW] != tx_rp[AW]) && (tx_wp[AW-1:0] == tx_rp[AW-1:0]);
  assign rx_empty = (rx_wp == rx_rp);
  assign rx_full  = (rx_wp[AW] != rx_rp[AW]) && (rx_wp[AW-1:0] == rx_rp[AW-1:0]);
  assign rx_data  = rx_mem[rx_rp[AW-1:0]];

  wire       load      = !shifting && armed && en && !tx_empty;
  wire       edge_now  = shifting && (tick == half_m1);
  wire       last      = edge_now && (ecnt == 4'd15);
  wire       lead      = !ecnt[0];
  wire       samp      = edge_now && (lead ^ cpha_l);
  wire       shift_out = edge_now && !last && (cpha_l ? (lead && ecnt != 4'd0) : !lead);
  wire [7:0] rx_word   = cpha_l ? {rx_sh[6:0], miso} : rx_sh;
  wire       tx_wr     = tx_push && !tx_full;
  wire       rx_wr     = last && !rx_full;
  wire       rx_rd     = rx_pop && !rx_empty;
  wire [2:0] d_eff     = (div == 3'd0) ? 3'd1 : div;

  assign busy = shifting || !tx_empty;
  assign sclk = sclk_r;
  assign mosi = sh[7];
  assign ss_n = ss_q;

  always_ff @(posedge clk) begin
    if (tx_wr) tx_mem[tx_wp[AW-1:0]] <= tx_data;
    if (rx_wr) rx_mem[rx_wp[AW-1:0]] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (tx_wr) tx_wp <= tx_wp + 1'b1;
      if (load)  tx_rp <= tx_rp + 1'b1;
      if (rx_wr) rx_wp <= rx_wp + 1'b1;
      if (rx_rd) rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; cpol_l <= 1'b0; cpha_l <= 1'b0; shifting <= 1'b0;
      sclk_r <= 1'b0; tick <= '0; half_m1 <= 7'd1; ecnt <= '0;
      sh <= '0; rx_sh <= '0;
    end else if (!shifting) begin
      sclk_r <= cpol_l;
      if (!en) armed <= 1'b0;
      else if (!armed) begin
        armed  <= 1'b1;
        cpol_l <= cpol;
        cpha_l <= cpha;
      end
      if (load) begin
        shifting <= 1'b1;
        sh       <= tx_mem[tx_rp[AW-1:0]];
        tick     <= '0;
        ecnt     <= '0;
        half_m1  <= 7'((8'd1 << d_eff) - 8'd1);
      end
    end else if (edge_now) begin
      tick   <= '0;
      sclk_r <= ~sclk_r;
      ecnt   <= ecnt + 4'd1;
      if (last)      shifting <= 1'b0;
      if (shift_out) sh <= {sh[6:0], 1'b0};
      if (samp)      rx_sh <= {rx_sh[6:0], miso};
    end else begin
      tick <= tick + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_q <= '1;
    else if (!sel_on) ss_q <= '1;
    else if (sel_decode) ss_q <= NSS'(sel_idx);
    else ss_q <= ~(NSS'(1) << sel_idx);
  end
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
  parameter int NSS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sel_on,
  input logic           sel_decode,
  input logic [NSS-1:0] ss_n,
  input logic           sclk,
  input logic           shifting,
  input logic           cpol_l,
  input logic           cpha_l,
  input logic           busy
);
  timeunit 1ns; timeprecision 100ps;

  // R8
  ss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_on |=> ss_n == '1);

  // R8
  ss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_on && !sel_decode |=> $countones(ss_n) == NSS - 1);

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |=> sclk == $past(cpol_l));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |=> $stable(cpol_l) && $stable(cpha_l));

  // R11
  busy_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> busy);
endmodule

bind spi_shift_master spi_shift_master_chk #(.NSS(NSS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_on(sel_on), .sel_decode(sel_decode),
  .ss_n(ss_n), .sclk(sclk), .shifting(shifting), .cpol_l(cpol_l),
  .cpha_l(cpha_l), .busy(busy)
);

// File: tb/sim_spi_shift_master.sv
module sim_spi_shift_master;
  timeunit 1ns; timeprecision 100ps;
  localparam int DEPTH = 128;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic en = 0, cpol = 0, cpha = 0, sel_on = 0, sel_decode = 0;
  logic [2:0] div = 3'd1;
  logic [1:0] sel_idx = 0;
  logic tx_push = 0, rx_pop = 0;
  logic [7:0] tx_data = 0;
  logic tx_full, rx_empty, busy, sclk, mosi, miso;
  logic [7:0] rx_data;
  logic [3:0] ss_n;

  assign miso = ~mosi;

  spi_shift_master u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha), .div(div),
    .sel_on(sel_on), .sel_decode(sel_decode), .sel_idx(sel_idx),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int checks = 0, errors = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  int rx_occ = 0;
  logic m_pol = 0, m_pha = 0;
  int m_half = 2;
  bit mon_on = 0;
  int cyc = 0;
  always @(negedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: rebuilds each byte from mosi at the sampling edges
  int tr_idx = 0, last_cyc = 0;
  logic [7:0] cap = 0, me;
  always @(sclk) if (mon_on && rst_n) begin
    if (tr_idx > 0) chk(cyc - last_cyc == m_half, "R3 half period", cyc - last_cyc, m_half);
    else chk(sclk == !m_pol, "R4 leading edge direction", sclk, !m_pol);
    last_cyc = cyc;
    if (((tr_idx % 2) == 0) != m_pha) cap = {cap[6:0], mosi};
    if (tr_idx == 15) begin
      if (exp_tx.size() == 0) chk(0, "R2 unexpected byte", cap, 0);
      else begin
        me = exp_tx.pop_front();
        chk(cap == me, "R2 R5 mosi byte", cap, me);
        if (rx_occ < DEPTH) begin exp_rx.push_back(~me); rx_occ++; end
      end
      tr_idx = 0;
    end else tr_idx++;
  end

  task automatic push(input logic [7:0] b);
    tx_data = b; tx_push = 1;
    if (exp_tx.size() < DEPTH) exp_tx.push_back(b);
    else chk(tx_full == 1, "R10 tx_full on overflow push", tx_full, 1);
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop_chk(input string req);
    if (exp_rx.size() == 0) chk(0, req, rx_data, 0);
    else begin
      me = exp_rx.pop_front();
      chk(!rx_empty && rx_data == me, req, rx_data, me);
      rx_occ--;
    end
    rx_pop = 1; @(negedge clk); rx_pop = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_mode(input logic p, input logic h, input logic [2:0] d);
    mon_on = 0; en = 0;
    @(negedge clk);
    wait_idle();
    cpol = p; cpha = h; div = d;
    @(negedge clk); en = 1;
    repeat (2) @(negedge clk);
    m_pol = p; m_pha = h; m_half = 1 << ((d == 0) ? 1 : d);
    mon_on = 1;
    chk(sclk == p, "R4 idle level after enable", sclk, p);
  endtask

  initial begin
    #(5.0 * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sclk == 0, "R1 sclk", sclk, 0);
    chk(ss_n == 4'hF, "R1 ss_n", ss_n, 4'hF);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(rx_empty == 1, "R1 rx_empty", rx_empty, 1);
    chk(tx_full == 0, "R1 tx_full", tx_full, 0);

    sel_on = 1; sel_idx = 2; sel_decode = 0; repeat (2) @(negedge clk);
    chk(ss_n == 4'b1011, "R8 one-hot index 2", ss_n, 4'b1011);
    sel_idx = 0; repeat (2) @(negedge clk);
    chk(ss_n == 4'b1110, "R8 one-hot index 0", ss_n, 4'b1110);
    sel_decode = 1; sel_idx = 2; repeat (2) @(negedge clk);
    chk(ss_n == 4'b0010, "R9 decode index 2", ss_n, 4'b0010);
    sel_idx = 3; repeat (2) @(negedge clk);
    chk(ss_n == 4'b0011, "R9 decode index 3", ss_n, 4'b0011);
    sel_on = 0; repeat (2) @(negedge clk);
    chk(ss_n == 4'hF, "R8 none selected", ss_n, 4'hF);

    // all four modes, several dividers
    for (int m = 0; m < 5; m++) begin
      case (m)
        0: set_mode(0, 0, 3'd1);
        1: set_mode(1, 0, 3'd2);
        2: set_mode(0, 1, 3'd0);
        3: set_mode(1, 1, 3'd3);
        default: set_mode(0, 0, 3'd7);
      endcase
      push(8'hA5 ^ 8'(m)); push(8'h3C + 8'(m)); push(8'h81);
      chk(busy == 1, "R11 busy with data", busy, 1);
      wait_idle();
      chk(busy == 0, "R11 busy clears", busy, 0);
      for (int k = 0; k < 3; k++) pop_chk("R2 received byte");
      chk(rx_empty == 1, "R2 one rx per tx", rx_empty, 1);
    end

    // R6: mode change while enabled is ignored
    set_mode(0, 0, 3'd1);
    cpol = 1; cpha = 1;
    repeat (4) @(negedge clk);
    chk(sclk == 0, "R6 cpol change ignored while enabled", sclk, 0);
    push(8'h5E);
    wait_idle();
    pop_chk("R6 byte in old mode");
    set_mode(1, 1, 3'd1);
    chk(sclk == 1, "R6 new polarity after re-enable", sclk, 1);

    // R7: enable drops mid-byte
    set_mode(0, 0, 3'd2);
    push(8'h11); push(8'h22); push(8'h33);
    repeat (10) @(negedge clk);
    en = 0;
    repeat (200) @(negedge clk);
    chk(busy == 1, "R7 R11 busy with queued data while disabled", busy, 1);
    chk(sclk == 0, "R7 sclk idle after stop", sclk, 0);
    pop_chk("R7 current byte completed");
    chk(rx_empty == 1, "R7 no further byte", rx_empty, 1);
    en = 1;
    wait_idle();
    pop_chk("R7 resumed byte"); pop_chk("R7 resumed byte");

    // R10: queue limits
    en = 0; @(negedge clk);
    for (int i = 0; i < DEPTH + 2; i++) push(8'(i * 7 + 1));
    chk(tx_full == 1, "R10 tx_full after DEPTH pushes", tx_full, 1);
    en = 1;
    wait_idle();
    chk(tx_full == 0, "R10 tx drained", tx_full, 0);
    push(8'hEE); push(8'hDD);
    wait_idle();
    for (int i = 0; i < DEPTH; i++) pop_chk("R10 oldest bytes kept");
    chk(rx_empty == 1, "R10 overflow bytes dropped", rx_empty, 1);
    chk(exp_tx.size() == 0, "R2 all bytes sent", exp_tx.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule